// File: doc/BRIEF.md
# Drive Interrupt Request Controller

This block produces the interrupt line that a storage drive presents to the host on a shared parallel interface. A single pending bit records that the drive has an interrupt for the host. Register access strobes, the drive's control bits, and pulses from the drive's transfer engine set and clear that bit. The line is driven only when this drive is selected and the host has left interrupts enabled. Otherwise the output enable is low and the pin is left to float.

The host clears the pending interrupt in three ways: by writing a new command, by reading status, or by putting the drive into reset (the hardware reset input or the software-reset control bit). Which events raise the interrupt depends on the command that is running. In PIO mode the interrupt is raised at the start of every data block, except that write-type commands skip it on their first block. In DMA mode the interrupt is raised only once, when the command completes. The transfer path supplies the block-ready and completion pulses. The block only counts and gates them.

Top module: `intrq_ctrl`

## Requirements
- R1: `intrq_oe` is 1 exactly when `drv_sel`=1 and `irq_dis`=0. `intrq` is 1 only while `intrq_oe`=1 and an interrupt is pending.
- R2: The pending interrupt is held while the output is disabled, and it appears on `intrq` in the same cycle that both gating conditions become true.
- R3: With `rst_n`=0 at a clock edge, the pending bit is 0 after that edge.
- R4: While `soft_rst`=1, the pending bit is cleared and no event raises it.
- R5: A command write (`cmd_wr`=1) clears the pending bit. Block-ready or completion pulses in that same cycle are discarded.
- R6: A status read (`stat_rd`=1) clears the pending bit, unless a raise event occurs in the same cycle, in which case the bit is 1.
- R7: In PIO mode (`xfer_dma`=0 at the command write), each `blk_rdy` pulse raises the interrupt one edge later.
- R8: Command-type codes 1, 2, 3 and 4 (format, write sectors, write buffer, write long) in PIO mode suppress the interrupt for the first `blk_rdy` after the command write. Later pulses raise it. Other codes raise it on the first pulse.
- R9: In DMA mode (`xfer_dma`=1 at the command write), `blk_rdy` never raises the interrupt. `cmd_done` raises it.
- R10: `cmd_done` raises the interrupt in PIO mode as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset bit of the device control register |
| irq_dis | input | 1 | Interrupt disable bit of the device control register |
| drv_sel | input | 1 | This drive is the selected drive |
| cmd_wr | input | 1 | Host write strobe of the command register, one cycle |
| stat_rd | input | 1 | Host read strobe of the status register, one cycle |
| cmd_type | input | CMD_W | Command class code, sampled with `cmd_wr` |
| xfer_dma | input | 1 | Transfer mode, sampled with `cmd_wr`: 0 PIO, 1 DMA |
| blk_rdy | input | 1 | Pulse: a data block is ready to transfer |
| cmd_done | input | 1 | Pulse: the command has completed |
| intrq | output | 1 | Interrupt level |
| intrq_oe | output | 1 | Output enable of the interrupt pin |

## Verification
If the latched mode or the first-block flag is wrong, the fault shows at the first block-ready pulse after the command write. `intrq` then rises one edge too early, or one pulse too late. If the pending bit is wrong, the fault shows on `intrq` in the cycle after the offending edge, but only while the drive is selected and enabled. For that reason the stimulus reopens the gate after every stretch of pulses that arrived while the output was disabled. Same-cycle collisions of clear and raise events are driven directly, because a priority fault is invisible in any other pattern.

// File: rtl/intrq_pkg.sv
// Shared types and defaults for the drive interrupt request controller.
package intrq_pkg;
    // Transfer mode latched at each command write.
    typedef enum logic {
        XFER_PIO = 1'b0,
        XFER_DMA = 1'b1
    } xfer_e;

    // Command classes whose first PIO block raises no interrupt (codes 1..4).
    localparam logic [7:0] DEF_SKIP_MASK = 8'b0001_1110;
endpackage

// File: rtl/intrq_cmd_track.sv
// Tracks the running command: latches the transfer mode and a first-block
// skip flag at each command write, and turns block-ready and completion
// pulses into raise requests.
// Assumes strobes are single-cycle and cmd_type/xfer_dma are valid with cmd_wr.
module intrq_cmd_track
    import intrq_pkg::*;
#(
    parameter int CMD_W = 3,
    parameter logic [(1<<CMD_W)-1:0] SKIP_MASK = DEF_SKIP_MASK[(1<<CMD_W)-1:0]
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_type,
    input  logic             xfer_dma,
    input  logic             blk_rdy,
    input  logic             cmd_done,
    output logic             raise_req
);
    xfer_e mode_q;
    logic  skip_q;
    logic  pio_blk;

    // Block pulse that counts in PIO mode.
    assign pio_blk = blk_rdy && (mode_q == XFER_PIO);

    // Latch the mode and skip flag; consume the flag on the first PIO block.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mode_q <= XFER_PIO;
            skip_q <= 1'b0;
        end else if (cmd_wr) begin
            mode_q <= xfer_e'(xfer_dma);
            skip_q <= SKIP_MASK[cmd_type] && !xfer_dma;
        end else if (pio_blk || cmd_done) begin
            skip_q <= 1'b0;
        end
    end

    // Raise on a counted block or on completion; never during a command write or reset.
    always_comb begin
        raise_req = !cmd_wr && !soft_rst && ((pio_blk && !skip_q) || cmd_done);
    end

    // R9
    // DMA mode: a block pulse on its own never raises.
    dma_blk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XFER_DMA && blk_rdy && !cmd_done) |-> !raise_req);

    // R8
    // The skip flag drops after the first PIO block is seen.
    skip_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_q && pio_blk && !cmd_wr && !soft_rst) |=> !skip_q);

    // R5
    // Nothing is raised in a command write cycle.
    wr_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> !raise_req);
endmodule

// File: rtl/intrq_pend.sv
// Pending-interrupt register.
// Priority: hardware reset, software reset, raise, then command-write/status-read clear.
// Assumes raise_req is already suppressed in command write cycles.
module intrq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic cmd_wr,
    input  logic stat_rd,
    input  logic raise_req,
    output logic pend
);
    // Update the pending bit by event priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend <= 1'b0;
        else if (soft_rst)         pend <= 1'b0;
        else if (raise_req)        pend <= 1'b1;
        else if (cmd_wr || stat_rd) pend <= 1'b0;
    end

    // R4
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !pend);

    // R5
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !pend);

    // R6
    stat_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && raise_req && !soft_rst) |=> pend);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !raise_req && !cmd_wr && !stat_rd) |=> $stable(pend));
endmodule

// File: rtl/intrq_gate.sv
// Output gating: drives the line only for a selected drive with interrupts enabled.
// Assumes the pin buffer floats the pad when the output enable is low.
module intrq_gate (
    input  logic pend,
    input  logic irq_dis,
    input  logic drv_sel,
    output logic intrq,
    output logic intrq_oe
);
    // Combine the gate conditions with the pending bit.
    always_comb begin
        intrq_oe = drv_sel && !irq_dis;
        intrq    = pend && intrq_oe;
    end

    // R1
    always_comb begin
        gate_level_chk: assert (!(intrq && !intrq_oe));
    end
endmodule

// File: rtl/intrq_ctrl.sv
// Top of the drive interrupt request controller: command tracking, pending
// register and output gating. All state is reset synchronously by rst_n.
module intrq_ctrl
    import intrq_pkg::*;
#(
    parameter int CMD_W = 3,
    parameter logic [(1<<CMD_W)-1:0] SKIP_MASK = DEF_SKIP_MASK[(1<<CMD_W)-1:0]
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             irq_dis,
    input  logic             drv_sel,
    input  logic             cmd_wr,
    input  logic             stat_rd,
    input  logic [CMD_W-1:0] cmd_type,
    input  logic             xfer_dma,
    input  logic             blk_rdy,
    input  logic             cmd_done,
    output logic             intrq,
    output logic             intrq_oe
);
    logic raise_req;
    logic pend;

    intrq_cmd_track #(.CMD_W(CMD_W), .SKIP_MASK(SKIP_MASK)) u_track (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_wr(cmd_wr),
        .cmd_type(cmd_type), .xfer_dma(xfer_dma), .blk_rdy(blk_rdy),
        .cmd_done(cmd_done), .raise_req(raise_req)
    );

    intrq_pend u_pend (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_wr(cmd_wr),
        .stat_rd(stat_rd), .raise_req(raise_req), .pend(pend)
    );

    intrq_gate u_gate (
        .pend(pend), .irq_dis(irq_dis), .drv_sel(drv_sel),
        .intrq(intrq), .intrq_oe(intrq_oe)
    );

    // R3
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !intrq);

    // R10
    done_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !cmd_wr && !soft_rst && drv_sel && !irq_dis) |=>
            (intrq || irq_dis || !drv_sel));
endmodule

// File: tb/tb_intrq_ctrl.sv
module tb_intrq_ctrl;
    logic clk = 1'b0;
    logic rst_n, soft_rst, irq_dis, drv_sel, cmd_wr, stat_rd, xfer_dma, blk_rdy, cmd_done;
    logic [2:0] cmd_type;
    logic intrq, intrq_oe;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    intrq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_dis(irq_dis),
        .drv_sel(drv_sel), .cmd_wr(cmd_wr), .stat_rd(stat_rd), .cmd_type(cmd_type),
        .xfer_dma(xfer_dma), .blk_rdy(blk_rdy), .cmd_done(cmd_done),
        .intrq(intrq), .intrq_oe(intrq_oe)
    );

    // Vector: {cw, type[2:0], dma, blk, done, srd, srst, dis, sel, exp_intrq, exp_oe}
    function automatic logic [13:0] vec(logic cw, logic [2:0] ct, logic dm, logic br,
                                        logic cd, logic sr, logic rs, logic ds, logic se,
                                        logic ei, logic eo);
        return {cw, ct, dm, br, cd, sr, rs, ds, se, ei, eo};
    endfunction

    localparam int NV = 31;
    localparam logic [13:0] TBL [NV] = '{
        vec(1,0,0,0,0,0,0,0,1, 0,1), // R5 read command write
        vec(0,0,0,1,0,0,0,0,1, 1,1), // R7 block raises
        vec(0,0,0,0,0,1,0,0,1, 0,1), // R6 status read clears
        vec(0,0,0,1,0,0,0,0,1, 1,1), // R7 next block raises
        vec(0,0,0,1,0,1,0,0,1, 1,1), // R6 raise wins over status read
        vec(0,0,0,0,0,0,0,1,1, 0,0), // R1 disabled floats
        vec(0,0,0,0,0,0,0,0,0, 0,0), // R1 deselected floats
        vec(0,0,0,0,0,0,0,0,1, 1,1), // R2 held pending appears
        vec(1,2,0,0,0,0,0,0,1, 0,1), // R5 write-sectors command clears
        vec(0,0,0,1,0,0,0,0,1, 0,1), // R8 first block skipped
        vec(0,0,0,1,0,0,0,0,1, 1,1), // R8 second block raises
        vec(1,2,0,1,0,0,0,0,1, 0,1), // R5 block in write cycle dropped
        vec(0,0,0,1,0,0,0,0,1, 0,1), // R8 still first block
        vec(0,0,0,0,1,0,0,0,1, 1,1), // R10 completion raises in PIO
        vec(1,0,1,0,0,0,0,0,1, 0,1), // R9 DMA command write
        vec(0,0,0,1,0,0,0,0,1, 0,1), // R9 DMA block ignored
        vec(0,0,0,1,0,0,0,0,1, 0,1), // R9 DMA block ignored
        vec(0,0,0,0,1,0,0,0,1, 1,1), // R9 DMA completion raises
        vec(0,0,0,0,0,0,1,0,1, 0,1), // R4 soft reset clears
        vec(0,0,0,0,1,0,1,0,1, 0,1), // R4 completion blocked by soft reset
        vec(1,3,0,0,0,0,0,0,1, 0,1), // R8 write-buffer command
        vec(0,0,0,1,0,0,0,1,1, 0,0), // R8 first block skipped, disabled
        vec(0,0,0,1,0,0,0,1,1, 0,0), // R2 raised while disabled
        vec(0,0,0,0,0,0,0,0,1, 1,1), // R2 appears on enable
        vec(1,1,0,0,0,0,0,0,1, 0,1), // R8 format command
        vec(0,0,0,1,0,0,0,0,1, 0,1), // R8 format first block skipped
        vec(1,4,0,0,0,0,0,0,1, 0,1), // R8 write-long command
        vec(0,0,0,1,0,0,0,0,1, 0,1), // R8 write-long first block skipped
        vec(0,0,0,1,0,0,0,0,1, 1,1), // R8 write-long second block
        vec(1,5,0,0,0,0,0,0,1, 0,1), // R8 other code
        vec(0,0,0,1,0,0,0,0,1, 1,1)  // R8 other code raises on first block
    };

    task automatic check(string tag, logic ei, logic eo);
        checks++;
        if (intrq !== ei || intrq_oe !== eo) begin
            fails++;
            $display("FAIL %s: intrq/oe actual %b/%b expected %b/%b", tag, intrq, intrq_oe, ei, eo);
        end
    endtask

    task automatic idle();
        cmd_wr = 0; stat_rd = 0; blk_rdy = 0; cmd_done = 0; soft_rst = 0;
        cmd_type = 0; xfer_dma = 0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0; irq_dis = 0; drv_sel = 1;
        repeat (3) @(posedge clk);
        #1 check("R3 reset state", 0, 1);
        @(negedge clk) rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cmd_wr, cmd_type, xfer_dma, blk_rdy, cmd_done, stat_rd, soft_rst, irq_dis, drv_sel}
                = TBL[i][13:2];
            @(posedge clk);
            #1 check($sformatf("vector %0d", i), TBL[i][1], TBL[i][0]);
        end

        // R3: hardware reset clears a pending interrupt
        @(negedge clk) idle(); irq_dis = 0; drv_sel = 1;
        @(posedge clk);
        #1 check("R3 pending before reset", 1, 1);
        @(negedge clk) rst_n = 0;
        @(posedge clk);
        #1 check("R3 reset clears pending", 0, 1);
        @(negedge clk) rst_n = 1;
        @(posedge clk);
        #1 check("R3 stays clear after reset", 0, 1);

        // R7: after reset the mode is PIO with no skip, so a block raises
        @(negedge clk) blk_rdy = 1;
        @(posedge clk);
        #1 check("R7 block after reset", 1, 1);
        @(negedge clk) blk_rdy = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule